// File: doc/BRIEF.md
# Vector Pairwise Intersection Mask Unit

This unit takes two vector operands of up to 512 bits and checks every element of the first against every element of the second. It collapses the resulting equality matrix in two directions in the same cycle. Each row gives one bit of a "left" mask: element i of the first operand found a partner somewhere in the second. Each column gives one bit of a "right" mask: element j of the second operand found a partner somewhere in the first. The two masks are written at once into an even/odd pair of registers in a small mask register file. Two read ports let later logic, or a bench, look at any register.

A request is a single-beat transfer on `req_valid`/`req_ready`. The unit never applies back-pressure: `req_ready` is always high, so every cycle with `req_valid` high is an accepted request. The operand, mode, destination and encoding fields only need to be valid in that cycle. A legal request writes the register pair on that clock edge and pulses `done` in the next cycle. An illegal request pulses `illegal` in the next cycle instead and writes nothing. The second operand can be replaced by its lowest element copied into every lane.

Top module: `pair_match_unit`

## Requirements
- R1: With `elem64`=0 the elements are 32 bits wide and with `elem64`=1 they are 64 bits wide. The `vlen` codes 0, 1 and 2 select 128, 256 and 512 bits. This gives 4/8/16 active elements for 32-bit data and 2/4/8 for 64-bit data. Element k occupies bits k*width upward.
- R2: In the even register, bit i is 1 exactly when active element i of `op_a` equals at least one active element of the effective second operand.
- R3: In the odd register, bit j is 1 exactly when active element j of the effective second operand equals at least one active element of `op_a`.
- R4: A legal request writes all 64 bits of both registers, so every bit at or above the active element count reads 0, whatever the register held before.
- R5: The even register written is `dst_id` with bit 0 forced to 0, and the odd register is that value plus 1. Both are written on the same edge and no other register changes.
- R6: When `bcast`=1, the lowest element of `op_b` (bits 31:0, or 63:0 for 64-bit data) is used in every lane of the second operand.
- R7: A request is illegal when `merge_sel` is nonzero, `zero_bit` is 1, or `vlen` is 3. An illegal request pulses `illegal` for one cycle, does not pulse `done`, and leaves every register unchanged.
- R8: Elements above the active count in either operand do not take part in any comparison, even when their values match.
- R9: `req_ready` is always 1. Results are visible on the read ports in the cycle after the accepting edge, and `done` is high for exactly that one cycle.
- R10: A synchronous `rst` clears all registers to 0 and holds `done` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always high; the unit accepts a request every cycle |
| op_a | input | 512 | First operand |
| op_b | input | 512 | Second operand (lowest element used when broadcasting) |
| elem64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| vlen | input | 2 | 0: 128, 1: 256, 2: 512 bits, 3: reserved |
| bcast | input | 1 | Copy the lowest element of op_b into every lane |
| dst_id | input | 3 | Destination register id; bit 0 is ignored |
| merge_sel | input | 3 | Encoding field that must be zero |
| zero_bit | input | 1 | Encoding bit that must be zero |
| rd_addr0 | input | 3 | Read port 0 address |
| rd_addr1 | input | 3 | Read port 1 address |
| done | output | 1 | One-cycle pulse after a legal write |
| illegal | output | 1 | One-cycle pulse after an illegal request |
| rd_data0 | output | 64 | Read port 0 data |
| rd_data1 | output | 64 | Read port 1 data |

## Verification
The bench builds the unit with its defaults: 512-bit operands, eight registers of 64 bits, and therefore 16 lanes of 32 bits. This makes every vector length and both element sizes reachable, including the 16-element case that fills all lanes. The 64-bit compare is built from two 32-bit lane compares, so the bench includes qwords whose low halves match and whose high halves differ. It also drives odd register ids and matching values placed above the active count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int LANE_W = 32;
  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_RSV = 2'd3
  } vlen_e;
endpackage

// File: rtl/pmu_lane_prep.sv
module pmu_lane_prep
  import pmu_pkg::*;
#(
  parameter int OPW = 512,
  localparam int LANES = OPW / LANE_W
) (
  input  logic [OPW-1:0]   op_b,
  input  logic             elem64,
  input  logic [1:0]       vlen,
  input  logic             bcast,
  output logic [OPW-1:0]   b_eff,
  output logic [LANES-1:0] elem_act
);
  // Number of active elements: 32-bit lanes scale with the length code,
  // and 64-bit data halves that count.
  logic [7:0] n_elem;
  always_comb begin
    n_elem = (8'd4 << vlen) >> elem64;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (!bcast) begin
        b_eff[k*LANE_W +: LANE_W] = op_b[k*LANE_W +: LANE_W];
      end else if (elem64) begin
        b_eff[k*LANE_W +: LANE_W] = op_b[(k%2)*LANE_W +: LANE_W];
      end else begin
        b_eff[k*LANE_W +: LANE_W] = op_b[LANE_W-1:0];
      end
    end
    assign elem_act[k] = (8'(k) < n_elem);
  end
endmodule

// File: rtl/pmu_pair_matrix.sv
module pmu_pair_matrix
  import pmu_pkg::*;
#(
  parameter int OPW = 512,
  localparam int LANES = OPW / LANE_W,
  localparam int HALF  = LANES / 2
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             elem64,
  input  logic [LANES-1:0] elem_act,
  output logic [LANES-1:0] row_hit,
  output logic [LANES-1:0] col_hit
);
  // Lane-level equality; 64-bit element equality reuses pairs of these.
  logic [LANES*LANES-1:0] eq32;
  logic [LANES*LANES-1:0] hit;

  for (genvar i = 0; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_col
      assign eq32[i*LANES+j] = (a[i*LANE_W +: LANE_W] == b[j*LANE_W +: LANE_W]);
      if (i < HALF && j < HALF) begin : g_wide
        assign hit[i*LANES+j] = elem_act[i] & elem_act[j] &
          (elem64 ? (eq32[(2*i)*LANES+2*j] & eq32[(2*i+1)*LANES+2*j+1])
                  : eq32[i*LANES+j]);
      end else begin : g_narrow
        assign hit[i*LANES+j] = elem_act[i] & elem_act[j] & ~elem64 &
                                eq32[i*LANES+j];
      end
    end
  end

  always_comb begin
    row_hit = '0;
    col_hit = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        row_hit[i] = row_hit[i] | hit[i*LANES+j];
        col_hit[j] = col_hit[j] | hit[i*LANES+j];
      end
    end
  end
endmodule

// File: rtl/pmu_mask_bank.sv
module pmu_mask_bank #(
  parameter int NREG = 8,
  parameter int MW   = 64,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_id,
  input  logic [MW-1:0]   wr_even,
  input  logic [MW-1:0]   wr_odd,
  input  logic [RA_W-1:0] rd_addr0,
  input  logic [RA_W-1:0] rd_addr1,
  output logic [MW-1:0]   rd_data0,
  output logic [MW-1:0]   rd_data1
);
  logic [MW-1:0]   regs [NREG];
  logic [NREG-1:0] we;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [RA_W-1:0] RID = RA_W'(r);
    // Shifting off bit 0 makes the pair selection ignore the id's low bit.
    assign we[r] = wr_en && ((RID >> 1) == (wr_id >> 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[r] <= '0;
      end else if (we[r]) begin
        regs[r] <= (r % 2 == 1) ? wr_odd : wr_even;
      end
    end
  end

  assign rd_data0 = regs[rd_addr0];
  assign rd_data1 = regs[rd_addr1];

  // R5: a write always touches exactly one even/odd pair.
  p_pair_write_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(we) == 0) || ($countones(we) == 2));
  p_pair_enable_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(we) == 2));
endmodule

// File: rtl/pair_match_unit.sv
module pair_match_unit
  import pmu_pkg::*;
#(
  parameter int OPW  = 512,
  parameter int NREG = 8,
  parameter int MW   = 64,
  localparam int LANES = OPW / LANE_W,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic            elem64,
  input  logic [1:0]      vlen,
  input  logic            bcast,
  input  logic [RA_W-1:0] dst_id,
  input  logic [2:0]      merge_sel,
  input  logic            zero_bit,
  input  logic [RA_W-1:0] rd_addr0,
  input  logic [RA_W-1:0] rd_addr1,
  output logic            done,
  output logic            illegal,
  output logic [MW-1:0]   rd_data0,
  output logic [MW-1:0]   rd_data1
);
  logic [OPW-1:0]   b_eff;
  logic [LANES-1:0] elem_act;
  logic [LANES-1:0] row_hit;
  logic [LANES-1:0] col_hit;
  logic             legal;
  logic             wr_en;

  assign req_ready = 1'b1;
  assign legal = (merge_sel == 3'd0) && !zero_bit && (vlen != VL_RSV);
  assign wr_en = req_valid && legal;

  pmu_lane_prep #(.OPW(OPW)) u_prep (
    .op_b     (op_b),
    .elem64   (elem64),
    .vlen     (vlen),
    .bcast    (bcast),
    .b_eff    (b_eff),
    .elem_act (elem_act)
  );

  pmu_pair_matrix #(.OPW(OPW)) u_matrix (
    .a        (op_a),
    .b        (b_eff),
    .elem64   (elem64),
    .elem_act (elem_act),
    .row_hit  (row_hit),
    .col_hit  (col_hit)
  );

  pmu_mask_bank #(.NREG(NREG), .MW(MW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_id    (dst_id),
    .wr_even  (MW'(row_hit)),
    .wr_odd   (MW'(col_hit)),
    .rd_addr0 (rd_addr0),
    .rd_addr1 (rd_addr1),
    .rd_data0 (rd_data0),
    .rd_data1 (rd_data1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= wr_en;
      illegal <= req_valid && !legal;
    end
  end

  // R2/R3: any row hit implies a column hit and the reverse.
  p_rowcol_agree_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((|row_hit) == (|col_hit)));
  // R8: hits never land on inactive elements.
  p_inactive_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((row_hit | col_hit) & ~elem_act) == '0));
  // R9: done follows an accepted request and never coincides with illegal.
  p_done_source_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid));
  p_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));
  // R7: the register file is unchanged across an illegal request.
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (illegal && $stable(rd_addr0)) |-> $stable(rd_data0));
endmodule

// File: tb/pair_match_unit_bench.sv
`timescale 1ns/1ps
module pair_match_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [511:0] op_a = '0;
  logic [511:0] op_b = '0;
  logic         elem64 = 1'b0;
  logic [1:0]   vlen = 2'd0;
  logic         bcast = 1'b0;
  logic [2:0]   dst_id = 3'd0;
  logic [2:0]   merge_sel = 3'd0;
  logic         zero_bit = 1'b0;
  logic [2:0]   rd_addr0 = 3'd0;
  logic [2:0]   rd_addr1 = 3'd0;
  logic         done;
  logic         illegal;
  logic [63:0]  rd_data0;
  logic [63:0]  rd_data1;

  int nchk  = 0;
  int nfail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  pair_match_unit u_pair_match_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .elem64(elem64), .vlen(vlen), .bcast(bcast),
    .dst_id(dst_id), .merge_sel(merge_sel), .zero_bit(zero_bit),
    .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .done(done), .illegal(illegal),
    .rd_data0(rd_data0), .rd_data1(rd_data1)
  );

  // Vector fields: [15] elem64, [14:13] vlen, [12] bcast, [11:9] dst, [7:0] seed
  localparam logic [15:0] VTAB [0:11] = '{
    16'h0003, 16'h2205, 16'h4407, 16'h8609,
    16'hA80B, 16'hCA0D, 16'h1011, 16'h3213,
    16'h9415, 16'hD617, 16'h4217, 16'h0C1D
  };

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [511:0] make_op(int seed, int salt);
    logic [511:0] v = '0;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = 32'((seed + k * salt) % 5);
    return v;
  endfunction

  function automatic void ref_model(input logic [511:0] a, input logic [511:0] b,
      input logic e64, input logic [1:0] vl, input logic bc,
      output logic [63:0] ev, output logic [63:0] od);
    int w = e64 ? 64 : 32;
    int n = (128 << vl) / w;
    logic [511:0] m = e64 ? 512'hFFFFFFFFFFFFFFFF : 512'hFFFFFFFF;
    logic [511:0] bb = b;
    if (bc) begin
      bb = '0;
      for (int k = 0; k < 512 / w; k++) bb = bb | ((b & m) << (k * w));
    end
    ev = '0;
    od = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if (((a >> (i * w)) & m) == ((bb >> (j * w)) & m)) begin
          ev[i] = 1'b1;
          od[j] = 1'b1;
        end
  endfunction

  task automatic issue(logic [511:0] a, logic [511:0] b, logic e64, logic [1:0] vl,
      logic bc, logic [2:0] dst, logic [2:0] ms, logic zb);
    @(negedge clk);
    op_a = a; op_b = b; elem64 = e64; vlen = vl; bcast = bc;
    dst_id = dst; merge_sel = ms; zero_bit = zb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_pair(logic [2:0] r0, logic [2:0] r1);
    rd_addr0 = r0; rd_addr1 = r1;
    #1;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ev, od;
    logic [511:0] a, b;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 illegal", 64'(illegal), 64'd0);
    rst = 1'b0;
    for (int r = 0; r < 8; r += 2) begin
      read_pair(3'(r), 3'(r + 1));
      chk("R10 reg even", rd_data0, 64'd0);
      chk("R10 reg odd", rd_data1, 64'd0);
    end
    chk("R9 ready", 64'(req_ready), 64'd1);

    // Table walk: R1 R2 R3 (R6 when broadcasting), R5 destination, R9 done
    for (int v = 0; v < 12; v++) begin
      logic [15:0] e = VTAB[v];
      logic [2:0] base = {e[11:10], 1'b0};
      a = make_op(e[7:0], e[7:0] % 3 + 1);
      b = make_op(e[7:0] + 2, e[7:0] % 4 + 2);
      ref_model(a, b, e[15], e[14:13], e[12], ev, od);
      issue(a, b, e[15], e[14:13], e[12], e[11:9], 3'd0, 1'b0);
      chk("R9 done pulse", 64'(done), 64'd1);
      read_pair(base, base + 3'd1);
      chk(e[12] ? "R6 R2 even mask" : "R1 R2 even mask", rd_data0, ev);
      chk(e[12] ? "R6 R3 odd mask" : "R1 R3 odd mask", rd_data1, od);
      @(negedge clk);
      chk("R9 done single cycle", 64'(done), 64'd0);
    end

    // R4: all elements equal at 128 bits over a fully set register
    issue({16{32'h7}}, {16{32'h7}}, 1'b0, 2'd2, 1'b0, 3'd6, 3'd0, 1'b0);
    issue({16{32'h7}}, {16{32'h7}}, 1'b0, 2'd0, 1'b0, 3'd7, 3'd0, 1'b0);
    read_pair(3'd6, 3'd7);
    chk("R4 even upper zero", rd_data0, 64'h000F);
    chk("R4 odd upper zero", rd_data1, 64'h000F);

    // R8: matches only beyond the active count
    a = '0; b = '0;
    for (int k = 0; k < 16; k++) begin
      a[k*32 +: 32] = 32'(100 + k);
      b[k*32 +: 32] = 32'(200 + k);
    end
    a[5*32 +: 32] = 32'h55; b[6*32 +: 32] = 32'h55;
    issue(a, b, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0);
    read_pair(3'd0, 3'd1);
    chk("R8 even inactive", rd_data0, 64'd0);
    chk("R8 odd inactive", rd_data1, 64'd0);

    // R1: qwords equal in low half only do not match; full qword does
    a = '0; b = '0;
    a[63:0] = 64'h1111_0000_0000_0042; b[63:0] = 64'h2222_0000_0000_0042;
    a[127:64] = 64'hAAAA_BBBB_CCCC_DDDD; b[191:128] = 64'hAAAA_BBBB_CCCC_DDDD;
    a[191:128] = 64'h9; a[255:192] = 64'h9; b[127:64] = 64'h8; b[255:192] = 64'h7;
    issue(a, b, 1'b1, 2'd1, 1'b0, 3'd2, 3'd0, 1'b0);
    read_pair(3'd2, 3'd3);
    chk("R1 qword even", rd_data0, 64'h2);
    chk("R1 qword odd", rd_data1, 64'h4);

    // R5: odd id writes pair 4/5, pair 2/3 untouched
    issue({16{32'h3}}, {16{32'h3}}, 1'b0, 2'd1, 1'b0, 3'd5, 3'd0, 1'b0);
    read_pair(3'd4, 3'd5);
    chk("R5 even of odd id", rd_data0, 64'hFF);
    chk("R5 odd of odd id", rd_data1, 64'hFF);
    read_pair(3'd2, 3'd3);
    chk("R5 neighbour even", rd_data0, 64'h2);
    chk("R5 neighbour odd", rd_data1, 64'h4);

    // R7: each illegal cause, file unchanged
    for (int t = 0; t < 3; t++) begin
      issue('0, '0, 1'b0, (t == 2) ? 2'd3 : 2'd0, 1'b0, 3'd4,
            (t == 0) ? 3'd1 : 3'd0, (t == 1));
      chk("R7 illegal pulse", 64'(illegal), 64'd1);
      chk("R7 no done", 64'(done), 64'd0);
      read_pair(3'd4, 3'd5);
      chk("R7 even kept", rd_data0, 64'hFF);
      chk("R7 odd kept", rd_data1, 64'hFF);
    end

    // R10: reset mid-run clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_pair(3'd4, 3'd5);
    chk("R10 cleared even", rd_data0, 64'd0);
    chk("R10 cleared odd", rd_data1, 64'd0);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule